// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps an asynchronous DRAM alive. After reset it holds the strobes idle for a start-up pause of a set number of clock cycles. It then runs a burst of CAS-before-RAS refresh cycles and only after that reports the memory as ready. From then on an interval timer creates one refresh obligation per period. Each obligation is served as a CAS-before-RAS cycle. These cycles use the DRAM's internal row counter, so the block drives no address.

The block shares the strobe bus with the normal access sequencer. When it has work it raises a bus request and waits for a grant before it drives RAS, both CAS lines and WE. Obligations that cannot be served at once are kept in a bounded backlog. When the backlog is full the block becomes urgent, and the host request path is gated off until the backlog drains. The host path is also gated off until initialization is done.

A parameter adds self refresh. The block enters it on request when no obligation is pending. It holds RAS and CAS low for a minimum time and gives a long precharge on exit.

Top module: `dram_refresh_sched`

## Requirements
- R1: For PAUSE_CYC cycles after reset release, bus_req_o and drive_o stay low, ras_no, both cas_no bits and ready_o stay at reset values (high, high, low).
- R2: After the pause, exactly INIT_CNT refresh cycles run, ready_o rises at the end of the precharge of the last one, and ready_o never falls again until reset.
- R3: Every refresh cycle drives both cas_no bits low for CSR_CYC cycles with ras_no high, then both low for RAS_CYC cycles, then both high for RP_CYC cycles before bus_req_o drops. we_no is high whenever drive_o is high.
- R4: drive_o rises only in the cycle after bus_gnt_i was seen high with bus_req_o high. bus_req_o stays high while drive_o is high.
- R5: Once ready, one refresh obligation is added every REF_INTERVAL cycles. The timer pauses during self refresh and its exit precharge.
- R6: Pending obligations saturate at MAX_DEBT. urgent_o is high exactly while MAX_DEBT obligations are pending. An obligation that arrives in the same cycle as a completion is not lost.
- R7: host_req_o follows host_req_i only while ready_o is high and urgent_o is low; otherwise it is low.
- R8: With SELF_REF_EN set, sref_req_i seen in idle with no pending obligation starts a cycle whose hold phase (sref_active_o high, ras_no and cas_no low) lasts at least SREF_MIN_CYC cycles and continues while sref_req_i stays high. It is followed by SREF_RP_CYC precharge cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_gnt_i | input | 1 | Strobe bus granted by the access sequencer |
| host_req_i | input | 1 | Host access request before gating |
| sref_req_i | input | 1 | Self refresh wanted (used when SELF_REF_EN=1) |
| bus_req_o | output | 1 | Strobe bus requested |
| drive_o | output | 1 | Block owns and drives the strobes this cycle |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 2 | Upper and lower column strobes, active low |
| we_no | output | 1 | Write enable, active low (held high) |
| ready_o | output | 1 | Initialization complete |
| urgent_o | output | 1 | Backlog full, refresh takes priority |
| host_req_o | output | 1 | Gated host request toward the sequencer |
| sref_active_o | output | 1 | Self refresh hold phase in progress |

## Verification
A wrong phase counter shows up at once as a strobe edge one cycle early or late. A wrong backlog count shows up within one refresh interval as an extra or missing bus request, and as urgent_o and host_req_o switching at the wrong time. A bad initialization count moves the rising edge of ready_o by a whole refresh cycle. The bench therefore compares every output against a behavioural model on every clock, so a drift is caught in the cycle it first reaches a port.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [2:0] {
    ST_PAUSE, ST_IDLE, ST_REQ, ST_CAS_LO, ST_RAS_LO, ST_PRE, ST_SREF, ST_SREXIT
  } drs_state_e;

  function automatic int drs_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/drs_interval_timer.sv
module drs_interval_timer #(
  parameter int INTERVAL = 3125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = $clog2(INTERVAL + 1);
  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  p_tick_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/drs_debt_ctr.sv
module drs_debt_ctr #(
  parameter int MAX_DEBT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic done_i,
  output logic empty_o,
  output logic full_o
);
  localparam int DW = $clog2(MAX_DEBT + 1);
  logic [DW-1:0] debt_q;
  logic          inc;

  // a tick while full is kept when a completion frees a slot in the same cycle
  assign inc     = tick_i && (!full_o || done_i);
  assign empty_o = (debt_q == '0);
  assign full_o  = (debt_q == DW'(MAX_DEBT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) debt_q <= '0;
    else         debt_q <= debt_q + DW'(inc) - DW'(done_i);
  end

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debt_q <= DW'(MAX_DEBT));
  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !empty_o);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import drs_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int INIT_CNT     = 8,
  parameter int REF_INTERVAL = 3125,
  parameter int MAX_DEBT     = 4,
  parameter int CSR_CYC      = 1,
  parameter int RAS_CYC      = 5,
  parameter int RP_CYC       = 4,
  parameter bit SELF_REF_EN  = 1'b1,
  parameter int SREF_MIN_CYC = 10000,
  parameter int SREF_RP_CYC  = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_gnt_i,
  input  logic       host_req_i,
  input  logic       sref_req_i,
  output logic       bus_req_o,
  output logic       drive_o,
  output logic       ras_no,
  output logic [1:0] cas_no,
  output logic       we_no,
  output logic       ready_o,
  output logic       urgent_o,
  output logic       host_req_o,
  output logic       sref_active_o
);
  localparam int MAXC = drs_max(drs_max(drs_max(PAUSE_CYC, SREF_MIN_CYC),
                                        drs_max(SREF_RP_CYC, RAS_CYC)),
                                drs_max(RP_CYC, CSR_CYC));
  localparam int TW = $clog2(MAXC + 1);
  localparam int IW = $clog2(INIT_CNT + 1);

  drs_state_e    state_q;
  logic [TW-1:0] tmr_q;
  logic [IW-1:0] init_left_q;
  logic          ready_q, sref_mode_q;
  logic          sref_go, tick, timer_en, done_per, pre_end;
  logic          debt_empty, debt_full;

  generate
    if (SELF_REF_EN) begin : g_sref
      assign sref_go = sref_req_i;
    end else begin : g_no_sref
      assign sref_go = 1'b0;
    end
  endgenerate

  assign pre_end  = (state_q == ST_PRE) && (tmr_q == TW'(RP_CYC - 1));
  assign done_per = pre_end && ready_q;
  assign timer_en = ready_q && (state_q != ST_SREF) && (state_q != ST_SREXIT);

  drs_interval_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(timer_en), .tick_o(tick)
  );

  drs_debt_ctr #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick), .done_i(done_per),
    .empty_o(debt_empty), .full_o(debt_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_PAUSE;
      tmr_q       <= '0;
      init_left_q <= IW'(INIT_CNT);
      ready_q     <= 1'b0;
      sref_mode_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_PAUSE:
          if (tmr_q == TW'(PAUSE_CYC - 1)) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        ST_IDLE:
          if (!ready_q) begin
            state_q <= ST_REQ; sref_mode_q <= 1'b0;
          end else if (sref_go && debt_empty) begin
            state_q <= ST_REQ; sref_mode_q <= 1'b1;
          end else if (!debt_empty) begin
            state_q <= ST_REQ; sref_mode_q <= 1'b0;
          end
        ST_REQ:
          if (bus_gnt_i) begin
            state_q <= ST_CAS_LO;
            tmr_q   <= '0;
          end
        ST_CAS_LO:
          if (tmr_q == TW'(CSR_CYC - 1)) begin
            state_q <= sref_mode_q ? ST_SREF : ST_RAS_LO;
            tmr_q   <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        ST_RAS_LO:
          if (tmr_q == TW'(RAS_CYC - 1)) begin
            state_q <= ST_PRE;
            tmr_q   <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        ST_PRE:
          if (pre_end) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            if (!ready_q) begin
              init_left_q <= init_left_q - 1'b1;
              if (init_left_q == IW'(1)) ready_q <= 1'b1;
            end
          end else tmr_q <= tmr_q + 1'b1;
        ST_SREF:
          if (tmr_q == TW'(SREF_MIN_CYC - 1)) begin
            if (!sref_go) begin
              state_q <= ST_SREXIT;
              tmr_q   <= '0;
            end
          end else tmr_q <= tmr_q + 1'b1;
        ST_SREXIT:
          if (tmr_q == TW'(SREF_RP_CYC - 1)) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign drive_o       = (state_q == ST_CAS_LO) || (state_q == ST_RAS_LO) ||
                         (state_q == ST_PRE) || (state_q == ST_SREF) ||
                         (state_q == ST_SREXIT);
  assign bus_req_o     = drive_o || (state_q == ST_REQ);
  assign ras_no        = !((state_q == ST_RAS_LO) || (state_q == ST_SREF));
  assign cas_no        = {2{!((state_q == ST_CAS_LO) || (state_q == ST_RAS_LO) ||
                              (state_q == ST_SREF))}};
  assign we_no         = 1'b1;
  assign ready_o       = ready_q;
  assign urgent_o      = debt_full;
  assign host_req_o    = host_req_i && ready_q && !debt_full;
  assign sref_active_o = (state_q == ST_SREF);

  p_cas_before_ras_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> $past(cas_no) == 2'b00);
  p_drive_after_gnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_o) |-> $past(bus_gnt_i && bus_req_o));
  p_quiet_pause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAUSE) |-> (ras_no && cas_no == 2'b11 && !bus_req_o && !ready_o));
  p_ready_sticks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  p_sref_min_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sref_active_o) |-> $past(tmr_q) == TW'(SREF_MIN_CYC - 1));
endmodule

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int PAUSE = 30, INIT = 8, IV = 40, MAXD = 3;
  localparam int CSR = 1, RAS = 5, RP = 4, SMIN = 20, SRP = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic gnt_i = 1'b0, host_i = 1'b0, sref_i = 1'b0;
  logic bus_req, drive, ras_n, we_n, ready, urgent, host_o, sref_act;
  logic [1:0] cas_n;

  always #5 clk = ~clk;

  dram_refresh_sched #(
    .PAUSE_CYC(PAUSE), .INIT_CNT(INIT), .REF_INTERVAL(IV), .MAX_DEBT(MAXD),
    .CSR_CYC(CSR), .RAS_CYC(RAS), .RP_CYC(RP), .SELF_REF_EN(1'b1),
    .SREF_MIN_CYC(SMIN), .SREF_RP_CYC(SRP)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_gnt_i(gnt_i), .host_req_i(host_i),
    .sref_req_i(sref_i), .bus_req_o(bus_req), .drive_o(drive), .ras_no(ras_n),
    .cas_no(cas_n), .we_no(we_n), .ready_o(ready), .urgent_o(urgent),
    .host_req_o(host_o), .sref_active_o(sref_act)
  );

  int n_run = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // behavioural model: 0 pause,1 idle,2 wait grant,3 cas,4 ras,5 precharge,6 self,7 self exit
  int ph, mt, minit, mival, mdebt;
  bit mready, msref;

  always @(posedge clk) begin
    bit tick, en, dn;
    cyc++;
    if (!rst_ni) begin
      ph = 0; mt = 0; minit = INIT; mready = 0; msref = 0; mival = 0; mdebt = 0;
    end else begin
      en   = mready && ph != 6 && ph != 7;
      tick = en && mival == IV - 1;
      dn   = 0;
      case (ph)
        0: if (mt == PAUSE - 1) begin ph = 1; mt = 0; end else mt++;
        1: if (!mready) begin ph = 2; msref = 0; end
           else if (sref_i && mdebt == 0) begin ph = 2; msref = 1; end
           else if (mdebt > 0) begin ph = 2; msref = 0; end
        2: if (gnt_i) begin ph = 3; mt = 0; end
        3: if (mt == CSR - 1) begin ph = msref ? 6 : 4; mt = 0; end else mt++;
        4: if (mt == RAS - 1) begin ph = 5; mt = 0; end else mt++;
        5: if (mt == RP - 1) begin
             ph = 1; mt = 0;
             if (!mready) begin minit--; if (minit == 0) mready = 1; end
             else dn = 1;
           end else mt++;
        6: if (mt == SMIN - 1) begin if (!sref_i) begin ph = 7; mt = 0; end end
           else mt++;
        7: if (mt == SRP - 1) begin ph = 1; mt = 0; end else mt++;
        default: ;
      endcase
      if (en) mival = (mival == IV - 1) ? 0 : mival + 1;
      if (tick && (mdebt < MAXD || dn)) mdebt++;
      if (dn) mdebt--;
    end
  end

  // per-clock comparison, away from the active edge
  int ras_falls_init = 0, sref_len = 0, last_sref_len = 0;
  bit prev_ras = 1'b1, prev_ready = 1'b0, seen_urgent = 1'b0;
  always @(negedge clk) begin
    bit e_drive, e_ras, e_cas;
    if (rst_ni) begin
      e_drive = ph >= 3;
      e_ras   = !(ph == 4 || ph == 6);
      e_cas   = !(ph == 3 || ph == 4 || ph == 6);
      chk(drive == e_drive, "R4 drive_o", drive, e_drive);
      chk(bus_req == (e_drive || ph == 2), "R4 bus_req_o", bus_req, e_drive || ph == 2);
      chk(ras_n == e_ras, "R3 ras_no", ras_n, e_ras);
      chk(cas_n == {2{e_cas}}, "R3 cas_no", cas_n, {2{e_cas}});
      chk(!drive || we_n, "R3 we_no", we_n, 1);
      chk(ready == mready, "R1/R2 ready_o", ready, mready);
      chk(urgent == (mdebt == MAXD), "R6 urgent_o", urgent, mdebt == MAXD);
      chk(host_o == (host_i && mready && mdebt != MAXD), "R7 host_req_o",
          host_o, host_i && mready && mdebt != MAXD);
      chk(sref_act == (ph == 6), "R8 sref_active_o", sref_act, ph == 6);
      if (!ready && prev_ras && !ras_n) ras_falls_init++;
      if (ready && !prev_ready) chk(ras_falls_init == INIT, "R2 init cycle count",
                                    ras_falls_init, INIT);
      if (urgent) seen_urgent = 1'b1;
      if (sref_act) sref_len++;
      else if (sref_len != 0) begin last_sref_len = sref_len; sref_len = 0; end
      prev_ras = ras_n; prev_ready = ready;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    chk(ras_n && cas_n == 2'b11 && !bus_req && !ready, "R1 reset state", ras_n, 1);
    rst_ni = 1'b1; gnt_i = 1'b1;
    for (int i = 0; i < 40; i++) begin host_i = i[0]; wait_cyc(10); end
    // bus held busy: backlog builds up to the limit
    gnt_i = 1'b0; host_i = 1'b1;
    wait_cyc(220);
    chk(seen_urgent, "R6 urgent seen", seen_urgent, 1);
    chk(!host_o, "R7 host blocked while urgent", host_o, 0);
    gnt_i = 1'b1;
    wait_cyc(150);
    // long self refresh request
    sref_i = 1'b1; wait_cyc(80); sref_i = 1'b0;
    wait_cyc(60);
    chk(last_sref_len >= SMIN, "R8 long hold", last_sref_len, SMIN);
    // short self refresh pulse must still hold the minimum
    @(negedge clk); while (!(ph == 1 && mdebt == 0)) @(negedge clk);
    sref_i = 1'b1; wait_cyc(3); sref_i = 1'b0;
    wait_cyc(60);
    chk(last_sref_len == SMIN, "R8 minimum hold", last_sref_len, SMIN);
    // grant delayed a few cycles at a time
    for (int i = 0; i < 30; i++) begin gnt_i = (i % 3 == 0); wait_cyc(7); end
    gnt_i = 1'b1; wait_cyc(200);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule